// File: doc/BRIEF.md
# Hitless Reference Switch Phase Detector

This block is the phase-detector front end of a PLL that can move between reference clocks without a jump in its output phase. A free-running tick counter runs in the output-clock domain. Each reference edge strobe latches the counter into that reference's timestamp register. At every feedback edge the block measures, for every reference and not only the selected one, how many ticks have passed since that reference's last edge. It then reports the phase error of the active reference as that measurement minus a stored per-reference offset.

When the select input asks for another reference, nothing happens until the next feedback edge. On that edge the block loads the new reference's offset with its measured phase minus the error currently on the output. It makes the new reference active and leaves the error output unchanged. The skew between the two references ends up in the offset, so the loop filter downstream sees a continuous error. All of the switching happens inside this block. The loop filter and the oscillator it steers are outside it.

Top module: `pbo_hitless_switch`

## Requirements
- R1: While `rst` is sampled high at a clock edge, the tick counter, all timestamps, all offsets, `phase_err`, `err_upd` and `active_ref` are cleared to zero at that edge. A reference that has no edge since reset is treated as stamped at tick 0.
- R2: `phase_err` and `active_ref` change only at a clock edge where `fb_edge` is sampled high. `err_upd` is high in the cycle after each such edge and low otherwise.
- R3: At a feedback edge where no switch is pending, `phase_err` takes the value ((number of cycles from the latest earlier edge of the active reference to this feedback edge) minus that reference's offset), as 16-bit two's complement. A reference edge in the same cycle as the feedback edge is counted only from the next feedback edge onward.
- R4: Every reference is measured at every feedback edge, including references that are not active. A switch uses the newly selected reference's measurement from that same feedback edge.
- R5: A switch is pending when `ref_sel` differs from `active_ref` at a feedback edge. On that edge `active_ref` takes `ref_sel`, and the new reference's offset becomes (its measurement minus the current `phase_err`). `phase_err` holds its previous value for that one update.
- R6: If two references have the same period and a fixed skew, the error after a switch differs from the error before it by at most one tick.
- R7: Switching back to a reference that was used earlier reloads its offset at that switch. The previously stored value is not reused.
- R8: A `ref_sel` change that is undone before the next feedback edge causes no switch.
- R9: A reset during operation discards the learned offsets. After it, the error equals the raw measured phase of reference 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Output-domain clock |
| rst | input | 1 | Synchronous reset, active high |
| ref_edge | input | NREF (2) | One-cycle edge strobes, one per reference, already synchronised |
| ref_sel | input | SELW (1) | Requested reference |
| fb_edge | input | 1 | One-cycle feedback (output clock) edge strobe |
| phase_err | output | TW (16) | Signed phase error in ticks |
| err_upd | output | 1 | High the cycle after a feedback edge was processed |
| active_ref | output | SELW (1) | Reference currently driving the error |

## Verification
The hardest case to produce from the ports is a switch between two references with a known skew. In that case the reported error must not move, while the offset absorbs the whole skew. Getting there needs the unselected reference to have a settled measurement, a select change, and then a feedback edge. The stimulus sweeps every reference-0 position and a spread of reference-1 positions inside the feedback period for two periods. Each run selects reference 0, switches to reference 1, and switches back. After every step the bench compares the error with an expected value computed from the edge positions. A short select glitch placed between feedback edges, and a run with unequal reference periods, cover the remaining orderings.

// File: rtl/pbo_pkg.sv
package pbo_pkg;
  // Kind of work done by the offset bank in the current cycle.
  typedef enum logic [1:0] {
    EV_NONE   = 2'd0,  // no feedback edge
    EV_TRACK  = 2'd1,  // feedback edge, error refreshed
    EV_REBASE = 2'd2   // feedback edge, switch taken, offset reloaded
  } pbo_event_e;
endpackage

// File: rtl/pbo_tick.sv
module pbo_tick #(
  parameter int TW = 16
) (
  input  logic          clk,
  input  logic          rst,
  output logic [TW-1:0] now
);
  always_ff @(posedge clk) begin
    if (rst) now <= '0;
    else     now <= now + 1'b1;
  end
endmodule

// File: rtl/pbo_stamp.sv
module pbo_stamp #(
  parameter int TW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          edge_in,
  input  logic [TW-1:0] now,
  output logic [TW-1:0] phase
);
  // Age of the last captured edge, modulo the counter width.
  function automatic logic [TW-1:0] age_of(input logic [TW-1:0] t_now,
                                           input logic [TW-1:0] t_then);
    return t_now - t_then;
  endfunction

  logic [TW-1:0] stamp_q;

  always_ff @(posedge clk) begin
    if (rst)          stamp_q <= '0;
    else if (edge_in) stamp_q <= now;
  end

  assign phase = age_of(now, stamp_q);
endmodule

// File: rtl/pbo_offset.sv
module pbo_offset
  import pbo_pkg::*;
#(
  parameter int NREF = 2,
  parameter int TW   = 16,
  parameter int SELW = 1
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      fb_edge,
  input  logic [SELW-1:0]           ref_sel,
  input  logic [NREF-1:0][TW-1:0]   meas,
  output logic [TW-1:0]             err,
  output logic                      upd,
  output logic [SELW-1:0]           act,
  output pbo_event_e                evt
);
  localparam logic [SELW:0] NREF_V = (SELW+1)'(NREF);

  // Error of one reference against its stored offset.
  function automatic logic [TW-1:0] err_of(input logic [TW-1:0] ph,
                                           input logic [TW-1:0] ofs);
    return ph - ofs;
  endfunction

  // Offset that keeps the present error when a new reference takes over.
  function automatic logic [TW-1:0] rebase(input logic [TW-1:0] ph,
                                           input logic [TW-1:0] keep);
    return ph - keep;
  endfunction

  logic [NREF-1:0][TW-1:0] off_q;
  logic [SELW-1:0]         act_q;
  logic [TW-1:0]           err_q;
  logic                    upd_q;
  logic                    sel_ok;
  logic                    want_swap;
  logic [TW-1:0]           meas_new;
  logic [TW-1:0]           meas_act;

  assign sel_ok    = {1'b0, ref_sel} < NREF_V;
  assign want_swap = sel_ok && (ref_sel != act_q);
  assign meas_new  = meas[ref_sel];
  assign meas_act  = meas[act_q];

  always_comb begin
    if (!fb_edge)       evt = EV_NONE;
    else if (want_swap) evt = EV_REBASE;
    else                evt = EV_TRACK;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      off_q <= '0;
      act_q <= '0;
      err_q <= '0;
      upd_q <= 1'b0;
    end else begin
      upd_q <= fb_edge;
      case (evt)
        EV_TRACK:  err_q <= err_of(meas_act, off_q[act_q]);
        EV_REBASE: begin
          off_q[ref_sel] <= rebase(meas_new, err_q);
          act_q          <= ref_sel;
        end
        default: ;
      endcase
    end
  end

  assign err = err_q;
  assign upd = upd_q;
  assign act = act_q;
endmodule

// File: rtl/pbo_hitless_switch.sv
module pbo_hitless_switch
  import pbo_pkg::*;
#(
  parameter int  NREF = 2,
  parameter int  TW   = 16,
  localparam int SELW = (NREF > 1) ? $clog2(NREF) : 1
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [NREF-1:0]      ref_edge,
  input  logic [SELW-1:0]      ref_sel,
  input  logic                 fb_edge,
  output logic signed [TW-1:0] phase_err,
  output logic                 err_upd,
  output logic [SELW-1:0]      active_ref
);
  logic [TW-1:0]           now;
  logic [NREF-1:0][TW-1:0] meas;
  logic [TW-1:0]           err_raw;
  pbo_event_e              sw_evt;

  pbo_tick #(.TW(TW)) u_tick (
    .clk (clk),
    .rst (rst),
    .now (now)
  );

  for (genvar gi = 0; gi < NREF; gi++) begin : g_ref
    pbo_stamp #(.TW(TW)) u_stamp (
      .clk     (clk),
      .rst     (rst),
      .edge_in (ref_edge[gi]),
      .now     (now),
      .phase   (meas[gi])
    );
  end

  pbo_offset #(.NREF(NREF), .TW(TW), .SELW(SELW)) u_offset (
    .clk     (clk),
    .rst     (rst),
    .fb_edge (fb_edge),
    .ref_sel (ref_sel),
    .meas    (meas),
    .err     (err_raw),
    .upd     (err_upd),
    .act     (active_ref),
    .evt     (sw_evt)
  );

  assign phase_err = $signed(err_raw);
endmodule

// File: rtl/pbo_hitless_checker.sv
module pbo_hitless_checker
  import pbo_pkg::*;
#(
  parameter int NREF = 2,
  parameter int TW   = 16,
  parameter int SELW = 1
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 fb_edge,
  input logic signed [TW-1:0] phase_err,
  input logic                 err_upd,
  input logic [SELW-1:0]      active_ref,
  input pbo_event_e           evt
);
  logic rst_d;
  always_ff @(posedge clk) rst_d <= rst;

  always @(negedge clk) begin
    if (rst_d === 1'b1) begin
      assert_reset_clear_R1: assert (phase_err == '0 && active_ref == '0 && !err_upd)
        else $error("outputs not cleared by reset");
    end
  end

  assert_quiet_R2: assert property (@(posedge clk) disable iff (rst)
    !fb_edge |=> ($stable(phase_err) && !err_upd));

  assert_upd_R2: assert property (@(posedge clk) disable iff (rst)
    fb_edge |=> err_upd);

  assert_swap_hold_R5: assert property (@(posedge clk) disable iff (rst)
    (evt == EV_REBASE) |=> ($stable(phase_err) && active_ref != $past(active_ref)));

  assert_sel_stable_R8: assert property (@(posedge clk) disable iff (rst)
    (evt != EV_REBASE) |=> $stable(active_ref));
endmodule

bind pbo_hitless_switch pbo_hitless_checker #(.NREF(NREF), .TW(TW), .SELW(SELW)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .fb_edge    (fb_edge),
  .phase_err  (phase_err),
  .err_upd    (err_upd),
  .active_ref (active_ref),
  .evt        (sw_evt)
);

// File: tb/sim_pbo_hitless_switch.sv
module sim_pbo_hitless_switch;
  localparam int NREF = 2;
  localparam int TW   = 16;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic                 rst = 1'b1;
  logic [NREF-1:0]      ref_edge = '0;
  logic                 ref_sel = 1'b0;
  logic                 fb_edge = 1'b0;
  logic signed [TW-1:0] phase_err;
  logic                 err_upd;
  logic                 active_ref;

  pbo_hitless_switch #(.NREF(NREF), .TW(TW)) u0 (
    .clk(clk), .rst(rst), .ref_edge(ref_edge), .ref_sel(ref_sel),
    .fb_edge(fb_edge), .phase_err(phase_err), .err_upd(err_upd),
    .active_ref(active_ref)
  );

  int checks = 0;
  int fails  = 0;

  // Behavioural expectation, tracked from the requirements.
  int unsigned   nowc;
  logic [TW-1:0] lr [NREF];
  logic [TW-1:0] off [NREF];
  logic [TW-1:0] merr;
  logic          act;
  logic          watch;
  logic [TW-1:0] held;

  task automatic chk(input string tag, input logic [TW-1:0] got, input logic [TW-1:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %0d expected %0d", tag, $signed(got), $signed(exp));
    end
  endtask

  task automatic model_clear();
    nowc = 0; merr = '0; act = 1'b0; watch = 1'b0; held = '0;
    for (int i = 0; i < NREF; i++) begin lr[i] = '0; off[i] = '0; end
  endtask

  task automatic do_reset();
    rst = 1'b1; ref_edge = '0; fb_edge = 1'b0; ref_sel = 1'b0;
    repeat (2) @(negedge clk);
    chk("R1 err", phase_err, '0);
    chk("R1 upd", TW'(err_upd), '0);
    chk("R1 act", TW'(active_ref), '0);
    rst = 1'b0;
    model_clear();
  endtask

  task automatic tick(input logic [NREF-1:0] r, input logic f, input logic s);
    logic [TW-1:0] ph [NREF];
    logic swapped;
    logic [TW-1:0] d;
    ref_edge = r; fb_edge = f; ref_sel = s;
    @(posedge clk);
    swapped = 1'b0;
    if (f) begin
      for (int i = 0; i < NREF; i++) ph[i] = TW'(nowc) - lr[i];
      if (s != act) begin
        off[s] = ph[s] - merr; act = s; swapped = 1'b1;
      end else begin
        merr = ph[act] - off[act];
      end
    end
    for (int i = 0; i < NREF; i++) if (r[i]) lr[i] = TW'(nowc);
    nowc++;
    @(negedge clk);
    chk(swapped ? "R5 hold" : (f ? "R3 err" : "R2 err"), phase_err, merr);
    chk("R2 upd", TW'(err_upd), TW'(f));
    chk(f ? "R5 act" : "R8 act", TW'(active_ref), TW'(act));
    if (swapped) begin
      held = phase_err; watch = 1'b1;
    end else if (f && watch) begin
      watch = 1'b0;
      d = phase_err - held;
      checks++;
      if (!(d == '0 || d == TW'(1) || d == '1)) begin
        fails++;
        $display("FAIL R6 step: got %0d expected %0d (+/-1)", phase_err, $signed(held));
      end
    end
  endtask

  task automatic run_seg(input int p0, input int p1, input int a, input int b,
                         input int pf, input int cycles, input logic s);
    for (int c = 0; c < cycles; c++) begin
      tick({(int'(nowc % p1) == b), (int'(nowc % p0) == a)}, (int'(nowc % pf) == 0), s);
    end
  endtask

  initial begin
    #(4 * 150000);
    checks++; fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    int raw0;
    model_clear();
    for (int k = 0; k < 2; k++) begin
      int p;
      p = (k == 0) ? 8 : 13;
      for (int a = 0; a < p; a++) begin
        for (int b = 0; b < p; b += 3) begin
          raw0 = (a == 0) ? p : p - a;
          do_reset();  // follows activity: offsets must be discarded
          run_seg(p, p, a, b, p, 4 * p, 1'b0);
          chk("R9 raw", phase_err, TW'(raw0));
          run_seg(p, p, a, b, p, 4 * p, 1'b1);
          chk("R4 after switch", phase_err, TW'(raw0));
          chk("R5 active", TW'(active_ref), TW'(1));
          run_seg(p, p, a, b, p, 4 * p, 1'b0);
          chk("R7 back", phase_err, TW'(raw0));
          chk("R7 active", TW'(active_ref), TW'(0));
        end
      end
    end
    // Select glitch between feedback edges.
    do_reset();
    run_seg(10, 10, 3, 7, 10, 20, 1'b0);
    run_seg(10, 10, 3, 7, 10, 1, 1'b0);
    run_seg(10, 10, 3, 7, 10, 3, 1'b1);
    run_seg(10, 10, 3, 7, 10, 16, 1'b0);
    chk("R8 no switch", TW'(active_ref), TW'(0));
    chk("R8 err", phase_err, TW'(7));
    // Unequal reference periods, switch both ways.
    do_reset();
    run_seg(10, 11, 2, 5, 10, 60, 1'b0);
    run_seg(10, 11, 2, 5, 10, 60, 1'b1);
    run_seg(10, 11, 2, 5, 10, 60, 1'b0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule